// File: doc/BRIEF.md
# Interrupt Status, Enable and Routing Unit

This unit collects up to 32 interrupt sources of a USB device controller. It presents them to the processor on two request lines: a normal IRQ line and a fast FIQ line. Each source has a pending bit. A one-cycle pulse on the matching hardware event input raises that bit, and firmware can raise it through the set register. Firmware lowers it with write-one-to-clear semantics. A per-source enable mask decides which pending bits may reach an output. A per-source routing bit picks the line that an enabled pending source drives.

Firmware reaches the unit through a small memory-mapped register port. Writes take a single-cycle strobe. Reads take a single-cycle strobe and return data on the following clock. A pending bit is kept while its source is masked, so an event that is already pending asserts its line as soon as firmware enables that source.

Top module: `irq_route_unit`

## Requirements
- R1: After synchronous reset, the pending, enable and routing registers read as zero, and both `irq_o` and `fiq_o` are low.
- R2: The enable register at byte offset 0x24 is read/write and holds one bit per source.
- R3: The routing register at byte offset 0x2C is read/write and holds one bit per source. A 0 selects `irq_o` and a 1 selects `fiq_o`.
- R4: Writing the set register at offset 0x28 raises every pending bit whose written bit is 1. Written 0 bits leave their pending bits as they are.
- R5: A read of offset 0x28 returns the current pending register, not the value last written there.
- R6: Writing the clear register at offset 0x34 lowers every pending bit whose written bit is 1. Written 0 bits have no effect, and a read of 0x34 returns zero.
- R7: A one-cycle high pulse on bit i of `hw_evt_i` raises pending bit i.
- R8: If a hardware event and a clear reach the same bit in the same cycle, the bit ends up set.
- R9: Pending bits are kept whatever the enable mask holds. Enabling a source whose bit is already pending asserts its selected line.
- R10: `irq_o` is the OR over sources of pending AND enable AND NOT route, and `fiq_o` is the OR of pending AND enable AND route. Both come from registers, so they reflect register contents one clock after those contents change.
- R11: The pending register reads at offset 0x20. Read data appears on the clock after the read strobe, and reads of unmapped offsets return zero.
- R12: Writes to the pending register's offset 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid the clock after `rd_en_i` |
| hw_evt_i | input | NSRC (32) | Hardware event pulses, one bit per source |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A hardware event pulse and a firmware clear write can land on the same pending bit in the same clock. The bench first sets a bit. It then drives that bit's event line high during the very cycle in which the clear register is written with the same bit. Reading the pending register afterwards must show the bit still set, while a clear with no competing event must lower it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam logic [31:0] OFS_PEND   = 32'h20;
  localparam logic [31:0] OFS_ENABLE = 32'h24;
  localparam logic [31:0] OFS_SET    = 32'h28;
  localparam logic [31:0] OFS_ROUTE  = 32'h2C;
  localparam logic [31:0] OFS_CLEAR  = 32'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PEND,
    SEL_ENABLE,
    SEL_SET,
    SEL_ROUTE,
    SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [31:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_PEND:   sel = SEL_PEND;
      OFS_ENABLE: sel = SEL_ENABLE;
      OFS_SET:    sel = SEL_SET;
      OFS_ROUTE:  sel = SEL_ROUTE;
      OFS_CLEAR:  sel = SEL_CLEAR;
      default:    sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/irq_regport.sv
module irq_regport
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NSRC   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NSRC-1:0]   pend_i,
  output logic [NSRC-1:0]   enable_o,
  output logic [NSRC-1:0]   route_o,
  output logic [NSRC-1:0]   fw_set_o,
  output logic [NSRC-1:0]   fw_clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_sel_e          sel;
  logic [NSRC-1:0]   wbits;
  logic [NSRC-1:0]   enable_q;
  logic [NSRC-1:0]   route_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  assign sel   = decode_ofs(32'(addr_i));
  assign wbits = wdata_i[NSRC-1:0];

  // Strobes toward the pending bank; a write to the pending offset produces none.
  assign fw_set_o = (wr_en_i && sel == SEL_SET)   ? wbits : '0;
  assign fw_clr_o = (wr_en_i && sel == SEL_CLEAR) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      route_q  <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_ENABLE) enable_q <= wbits;
      if (sel == SEL_ROUTE)  route_q  <= wbits;
    end
  end

  always_comb begin
    case (sel)
      SEL_PEND, SEL_SET: rd_mux = DATA_W'(pend_i);
      SEL_ENABLE:        rd_mux = DATA_W'(enable_q);
      SEL_ROUTE:         rd_mux = DATA_W'(route_q);
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign enable_o = enable_q;
  assign route_o  = route_q;
  assign rdata_o  = rdata_q;

  // R5
  set_alias_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && sel == SEL_SET) |=> (rdata_o == $past(DATA_W'(pend_i))));

  // R11
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && (sel == SEL_NONE || sel == SEL_CLEAR)) |=> (rdata_o == '0));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == SEL_ENABLE) |=> (enable_o == $past(wbits)));

  // R3
  route_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && sel == SEL_ROUTE) |=> (route_o == $past(wbits)));

endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] hw_evt_i,
  input  logic [NSRC-1:0] fw_set_i,
  input  logic [NSRC-1:0] fw_clr_i,
  output logic [NSRC-1:0] pend_o
);

  logic [NSRC-1:0] raise;

  assign raise = hw_evt_i | fw_set_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (rst)              bit_q <= 1'b0;
      else if (raise[i])    bit_q <= 1'b1;
      else if (fw_clr_i[i]) bit_q <= 1'b0;
    end
    assign pend_o[i] = bit_q;
  end

  // R8 / R7 / R4
  raise_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (raise != '0) |=> ((pend_o & $past(raise)) == $past(raise)));

  // R6
  clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
    ((fw_clr_i & ~raise) != '0) |=> ((pend_o & $past(fw_clr_i & ~raise)) == '0));

  // R9 / R12
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (raise == '0 && fw_clr_i == '0) |=> $stable(pend_o));

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] enable_i,
  input  logic [NSRC-1:0] route_i,
  output logic            irq_o,
  output logic            fiq_o
);

  logic [NSRC-1:0] live;
  logic [NSRC-1:0] to_irq;
  logic [NSRC-1:0] to_fiq;
  logic            irq_q;
  logic            fiq_q;

  assign live = pend_i & enable_i;

  for (genvar i = 0; i < NSRC; i++) begin : g_steer
    assign to_irq[i] = live[i] & ~route_i[i];
    assign to_fiq[i] = live[i] &  route_i[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= |to_irq;
      fiq_q <= |to_fiq;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  // R10
  quiet_lines_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & enable_i) == '0) |=> (!irq_o && !fiq_o));

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & enable_i & ~route_i) != '0) |=> irq_o);

  // R3
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_i & enable_i & route_i) != '0) |=> fiq_o);

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NSRC   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NSRC-1:0]   hw_evt_i,
  output logic              irq_o,
  output logic              fiq_o
);

  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] enable;
  logic [NSRC-1:0] route;
  logic [NSRC-1:0] fw_set;
  logic [NSRC-1:0] fw_clr;

  irq_regport #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NSRC  (NSRC)
  ) u_regport (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .pend_i  (pend),
    .enable_o(enable),
    .route_o (route),
    .fw_set_o(fw_set),
    .fw_clr_o(fw_clr),
    .rdata_o (rdata_o)
  );

  irq_pend_bank #(
    .NSRC(NSRC)
  ) u_pend (
    .clk     (clk),
    .rst     (rst),
    .hw_evt_i(hw_evt_i),
    .fw_set_i(fw_set),
    .fw_clr_i(fw_clr),
    .pend_o  (pend)
  );

  irq_line_merge #(
    .NSRC(NSRC)
  ) u_merge (
    .clk     (clk),
    .rst     (rst),
    .pend_i  (pend),
    .enable_i(enable),
    .route_i (route),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !fiq_o));

endmodule

// File: tb/tb_irq_route_unit.sv
`timescale 1ns/1ps
module tb_irq_route_unit;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int NSRC   = 32;

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] rt;
    logic [31:0] st;
    logic        irq;
    logic        fiq;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{en: 32'h0000_0000, rt: 32'h0000_0000, st: 32'h0000_0001, irq: 1'b0, fiq: 1'b0},
    '{en: 32'h0000_0001, rt: 32'h0000_0000, st: 32'h0000_0001, irq: 1'b1, fiq: 1'b0},
    '{en: 32'h0000_0001, rt: 32'h0000_0001, st: 32'h0000_0001, irq: 1'b0, fiq: 1'b1},
    '{en: 32'h0000_FF00, rt: 32'h0000_0F00, st: 32'h0000_0100, irq: 1'b0, fiq: 1'b1},
    '{en: 32'hFFFF_FFFF, rt: 32'h8000_0000, st: 32'h8000_0001, irq: 1'b1, fiq: 1'b1},
    '{en: 32'h0000_FFFF, rt: 32'h0000_0000, st: 32'hFFFF_0000, irq: 1'b0, fiq: 1'b0},
    '{en: 32'h8000_0000, rt: 32'h0000_0000, st: 32'h8000_0000, irq: 1'b1, fiq: 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [NSRC-1:0]   hw_evt = '0;
  logic              irq;
  logic              fiq;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  irq_route_unit #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NSRC  (NSRC)
  ) dut (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (wr_en),
    .rd_en_i (rd_en),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .hw_evt_i(hw_evt),
    .irq_o   (irq),
    .fiq_o   (fiq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 fiq", {31'b0, fiq}, 32'h0);
    rd(8'h20, d); chk("R1 pend", d, 32'h0);
    rd(8'h24, d); chk("R1 enable", d, 32'h0);
    rd(8'h2C, d); chk("R1 route", d, 32'h0);

    // Vector table: R10 / R4 / R5 over several mask patterns
    for (int i = 0; i < NVEC; i++) begin
      wr(8'h34, 32'hFFFF_FFFF);
      wr(8'h24, VECS[i].en);
      wr(8'h2C, VECS[i].rt);
      wr(8'h28, VECS[i].st);
      settle();
      chk("R10 irq", {31'b0, irq}, {31'b0, VECS[i].irq});
      chk("R10 fiq", {31'b0, fiq}, {31'b0, VECS[i].fiq});
      rd(8'h28, d); chk("R5 set reads pend", d, VECS[i].st);
    end

    // R2 / R3: readback
    wr(8'h24, 32'hA5A5_5A5A);
    rd(8'h24, d); chk("R2 enable readback", d, 32'hA5A5_5A5A);
    wr(8'h2C, 32'h1234_5678);
    rd(8'h2C, d); chk("R3 route readback", d, 32'h1234_5678);

    // R4: zero bits written to set have no effect
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h28, 32'h0000_0C00);
    wr(8'h28, 32'h0000_0000);
    rd(8'h20, d); chk("R4 zero set no effect", d, 32'h0000_0C00);

    // R6: clear semantics
    wr(8'h34, 32'h0000_0000);
    rd(8'h20, d); chk("R6 zero clear no effect", d, 32'h0000_0C00);
    wr(8'h34, 32'h0000_0400);
    rd(8'h20, d); chk("R6 clear one bit", d, 32'h0000_0800);
    rd(8'h34, d); chk("R6 clear reads zero", d, 32'h0);

    // R12: writes to the pending offset are ignored
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R12 pend write ignored", d, 32'h0000_0800);

    // R11: unmapped offsets read zero
    rd(8'h40, d); chk("R11 unmapped 0x40", d, 32'h0);
    rd(8'h00, d); chk("R11 unmapped 0x00", d, 32'h0);

    // R7 / R9: event pulse held while masked, then enabled
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h24, 32'h0000_0000);
    wr(8'h2C, 32'h0000_0000);
    @(negedge clk);
    hw_evt = 32'h0000_0008;
    @(negedge clk);
    hw_evt = '0;
    settle();
    chk("R9 masked irq low", {31'b0, irq}, 32'h0);
    rd(8'h20, d); chk("R7 event sets pend", d, 32'h0000_0008);
    wr(8'h24, 32'h0000_0008);
    chk("R10 one-cycle latency", {31'b0, irq}, 32'h0);
    settle();
    chk("R9 enable reveals pending", {31'b0, irq}, 32'h1);

    // R8: event and clear on the same bit in the same cycle
    wr(8'h28, 32'h0000_0020);
    @(negedge clk);
    hw_evt = 32'h0000_0020;
    wr_en = 1'b1; addr = 8'h34; wdata = 32'h0000_0020;
    @(negedge clk);
    hw_evt = '0;
    wr_en = 1'b0;
    rd(8'h20, d); chk("R8 set wins over clear", d, 32'h0000_0028);

    report();
  end

endmodule